// File: doc/BRIEF.md
# AHB Bus Duration Event Counters

This block sits beside an AHB bus and only observes it. On every clock it decodes the bus control signals into duration events: cycles that carry write data, cycles that carry read data, and idle cycles. It keeps one counter for each of these events across the whole bus. For each master it keeps four more counters: cycles with its grant asserted, cycles in which it owns the data phase, and its own write and read data cycles. Software or a debug agent can use these counts to work out bus utilisation, per-master bandwidth and overhead.

The block learns the data-phase owner by registering the master number whenever the bus is ready. A master's data cycles are credited to that registered owner, not to the master currently presenting an address. A cycle in which some grant is asserted but no data moves, because the master inserts BUSY or the slave holds ready low, counts as overhead and never as idle.

A small control interface turns counting on and off, clears every counter at once, and reads any counter with its sticky overflow flag. Reads have no side effects.

Top module: `ahb_dur_mon`

## Requirements
- R1: HTRANS is encoded IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. The bus write counter (index 0) adds one on each counted clock with hwrite=1, hready=1 and HTRANS NONSEQ or SEQ.
- R2: The bus read counter (index 1) adds one on each counted clock with hwrite=0, hready=1 and HTRANS NONSEQ or SEQ. No clock increments both index 0 and index 1.
- R3: The idle counter (index 2) adds one only on clocks where every hgrant bit is 0. A granted cycle with hready=0 or HTRANS BUSY counts as neither idle nor data.
- R4: For master m, the grant counter (index 3+4m) adds one on each counted clock where hgrant[m]=1.
- R5: On each clock with hready=1, hmaster is registered as the data-phase owner. The owner stays unchanged while hready=0. For master m, the ownership counter (index 4+4m) adds one on each counted clock where a registered owner exists and equals m.
- R6: For master m, the write counter (index 5+4m) and the read counter (index 6+4m) add one on write or read data cycles (as in R1 and R2) whose registered owner is m.
- R7: While cnt_en=0 no counter changes. Ownership tracking continues, so the owner registered while disabled is credited once counting resumes.
- R8: cnt_clr=1 on a clock sets every counter and every overflow flag to zero at that edge, regardless of cnt_en or any event on that clock.
- R9: Counters are CNT_W bits wide (default 32). An increment from all-ones wraps to 0 and sets that counter's sticky overflow flag, which only a clear removes.
- R10: During reset all counters, overflow flags and ownership state are zero. Nothing is counted or registered on the first clock edge after reset is released.
- R11: rd_idx selects a counter. One clock later rd_data and rd_ovf show the value the counter held before that edge. An index of 3+4*NM or above reads as zero, and a read never changes any counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwrite | input | 1 | Observed transfer direction, 1 = write |
| hready | input | 1 | Observed transfer-done signal |
| htrans | input | 2 | Observed transfer type |
| hgrant | input | NM | Observed grant, one bit per master |
| hmaster | input | MW | Observed number of the master owning the address phase |
| cnt_en | input | 1 | Global count enable |
| cnt_clr | input | 1 | Synchronous clear of all counters and flags |
| rd_idx | input | IW | Counter select for reading |
| rd_data | output | CNT_W | Registered value of the selected counter |
| rd_ovf | output | 1 | Registered overflow flag of the selected counter |

## Verification
The assertions assume that the bus follows AHB ordering. This means hmaster names a valid master below NM, and a data cycle always follows some clock that registered an owner. The stimulus keeps to this by driving the bus with explicit per-cycle tasks. It registers an owner before the first data cycle is credited, keeps hmaster in range, and holds hgrant to at most one bit except in a deliberate multi-grant cycle that tests the per-master grant counters. Control inputs change only between clock edges, and reads are issued with counting disabled, so each expected value is fixed when it is queued.

// File: rtl/ahb_dur_pkg.sv
package ahb_dur_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } htrans_e;

  // bus-wide event slots
  localparam int GLB_EVENTS = 3;
  localparam int GI_WR      = 0;
  localparam int GI_RD      = 1;
  localparam int GI_IDLE    = 2;

  // per-master event slots, offset GLB_EVENTS + PER_MST * m
  localparam int PER_MST = 4;
  localparam int PM_GNT  = 0;
  localparam int PM_OWN  = 1;
  localparam int PM_WR   = 2;
  localparam int PM_RD   = 3;

endpackage

// File: rtl/ahb_dur_decode.sv
module ahb_dur_decode
  import ahb_dur_pkg::*;
#(
  parameter int NM  = 4,
  parameter int MW  = 2,
  parameter int NEV = GLB_EVENTS + PER_MST * NM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          hwrite_i,
  input  logic          hready_i,
  input  logic [1:0]    htrans_i,
  input  logic [NM-1:0] hgrant_i,
  input  logic [MW-1:0] hmaster_i,
  output logic [NEV-1:0] ev_o
);

  logic [MW-1:0] owner_q, owner_d;
  logic          own_vld_q, own_vld_d;
  logic          xfer;
  logic [NM-1:0] own_vec;

  // next-state: data-phase owner follows hmaster whenever the bus is ready
  always_comb begin
    owner_d   = owner_q;
    own_vld_d = own_vld_q;
    if (run_i && hready_i) begin
      owner_d   = hmaster_i;
      own_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q   <= '0;
      own_vld_q <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      own_vld_q <= own_vld_d;
    end
  end

  always_comb begin
    xfer = hready_i &&
           (htrans_e'(htrans_i) == TR_NSEQ || htrans_e'(htrans_i) == TR_SEQ);
    for (int m = 0; m < NM; m++) begin
      own_vec[m] = own_vld_q && (owner_q == MW'(m));
    end
    ev_o          = '0;
    ev_o[GI_WR]   = xfer && hwrite_i;
    ev_o[GI_RD]   = xfer && !hwrite_i;
    ev_o[GI_IDLE] = (hgrant_i == '0);
    for (int m = 0; m < NM; m++) begin
      ev_o[GLB_EVENTS + PER_MST*m + PM_GNT] = hgrant_i[m];
      ev_o[GLB_EVENTS + PER_MST*m + PM_OWN] = own_vec[m];
      ev_o[GLB_EVENTS + PER_MST*m + PM_WR]  = own_vec[m] && xfer && hwrite_i;
      ev_o[GLB_EVENTS + PER_MST*m + PM_RD]  = own_vec[m] && xfer && !hwrite_i;
    end
  end

  // R2: a clock is never both a write and a read data cycle
  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_o[GI_WR] && ev_o[GI_RD]));

  // R5: at most one master owns the data phase
  p_own_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_vec));

  // R5: owner is held through wait states
  p_owner_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> $stable(owner_q));

  // R3: a granted cycle is never idle
  p_overhead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hgrant_i) |-> !ev_o[GI_IDLE]);

  for (genvar m = 0; m < NM; m++) begin : g_chk
    // R6: data credited only to the master owning the data phase
    p_credit_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_o[GLB_EVENTS + PER_MST*m + PM_WR] || ev_o[GLB_EVENTS + PER_MST*m + PM_RD])
        |-> ev_o[GLB_EVENTS + PER_MST*m + PM_OWN]);
  end

endmodule

// File: rtl/ahb_dur_counter.sv
module ahb_dur_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr_i) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
      if (&cnt_q) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R8: clear empties counter and flag
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0) && !ovf_o);

  // R7: no increment, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(cnt_o) && $stable(ovf_o));

  // R9: increment from all-ones wraps and flags
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && inc_i && (&cnt_o)) |=> (cnt_o == '0) && ovf_o);

  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o);

endmodule

// File: rtl/ahb_dur_mon.sv
module ahb_dur_mon
  import ahb_dur_pkg::*;
#(
  parameter int NM    = 4,
  parameter int CNT_W = 32,
  localparam int MW   = (NM > 1) ? $clog2(NM) : 1,
  localparam int NEV  = GLB_EVENTS + PER_MST * NM,
  localparam int IW   = $clog2(NEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hwrite,
  input  logic             hready,
  input  logic [1:0]       htrans,
  input  logic [NM-1:0]    hgrant,
  input  logic [MW-1:0]    hmaster,
  input  logic             cnt_en,
  input  logic             cnt_clr,
  input  logic [IW-1:0]    rd_idx,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_ovf
);

  logic                 run_q;
  logic [NEV-1:0]       ev;
  logic [NEV-1:0]       inc;
  logic                 clr;
  logic [CNT_W-1:0]     cnt_a [NEV];
  logic [NEV-1:0]       ovf_a;
  logic [CNT_W-1:0]     rd_data_d;
  logic                 rd_ovf_d;

  // first edge after reset release only arms the block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  ahb_dur_decode #(.NM(NM), .MW(MW), .NEV(NEV)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .hwrite_i  (hwrite),
    .hready_i  (hready),
    .htrans_i  (htrans),
    .hgrant_i  (hgrant),
    .hmaster_i (hmaster),
    .ev_o      (ev)
  );

  assign inc = (run_q && cnt_en) ? ev : '0;
  assign clr = run_q && cnt_clr;

  for (genvar i = 0; i < NEV; i++) begin : g_ctr
    ahb_dur_counter #(.CW(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .inc_i (inc[i]),
      .cnt_o (cnt_a[i]),
      .ovf_o (ovf_a[i])
    );
  end

  always_comb begin
    rd_data_d = '0;
    rd_ovf_d  = 1'b0;
    for (int i = 0; i < NEV; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_data_d = cnt_a[i];
        rd_ovf_d  = ovf_a[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ovf  <= 1'b0;
    end else begin
      rd_data <= rd_data_d;
      rd_ovf  <= rd_ovf_d;
    end
  end

  // R10: nothing counted on the arming edge
  p_arm_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (ovf_a == '0) && (cnt_a[GI_IDLE] == '0) && (cnt_a[GI_WR] == '0));

  // R11: out-of-range index reads zero
  p_rd_oor_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IW'(NEV)) |=> (rd_data == '0) && !rd_ovf);

endmodule

// File: tb/ahb_dur_mon_test.sv
module ahb_dur_mon_test;

  localparam int CLK_PERIOD = 10;
  localparam int NM  = 4;
  localparam int CW  = 6;
  localparam int NEV = 3 + 4 * NM;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hwrite, hready;
  logic [1:0]    htrans;
  logic [NM-1:0] hgrant;
  logic [1:0]    hmaster;
  logic          cnt_en, cnt_clr;
  logic [4:0]    rd_idx;
  logic [CW-1:0] rd_data;
  logic          rd_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_dur_mon #(.NM(NM), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .hwrite(hwrite), .hready(hready), .htrans(htrans),
    .hgrant(hgrant), .hmaster(hmaster), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_ovf(rd_ovf)
  );

  typedef struct { int idx; int unsigned val; bit ovf; string tag; } exp_t;
  exp_t sb_q[$];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state derived from the requirements
  int unsigned mcnt [NEV];
  bit          movf [NEV];
  int          own;
  bit          own_vld;
  bit          skip;
  bit          rd_pend, rd_pend_q;

  function automatic void bump(int i);
    if (mcnt[i] == MAXV) begin mcnt[i] = 0; movf[i] = 1'b1; end
    else mcnt[i]++;
  endfunction

  // one bus clock; called and returns at a falling edge
  task automatic cyc(bit wr, bit rdy, logic [1:0] tr, logic [NM-1:0] gnt,
                     int mst, bit en, bit clr);
    bit xfer;
    hwrite = wr; hready = rdy; htrans = tr; hgrant = gnt;
    hmaster = 2'(mst); cnt_en = en; cnt_clr = clr;
    xfer = rdy && (tr == 2'b10 || tr == 2'b11);
    if (!skip) begin
      if (clr) begin
        for (int i = 0; i < NEV; i++) begin mcnt[i] = 0; movf[i] = 0; end
      end else if (en) begin
        if (xfer && wr)  bump(0);
        if (xfer && !wr) bump(1);
        if (gnt == '0)   bump(2);
        for (int m = 0; m < NM; m++) begin
          if (gnt[m]) bump(3 + 4*m);
          if (own_vld && own == m) begin
            bump(4 + 4*m);
            if (xfer && wr)  bump(5 + 4*m);
            if (xfer && !wr) bump(6 + 4*m);
          end
        end
      end
      if (rdy) begin own = mst; own_vld = 1'b1; end
    end
    skip = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(int idx, string tag);
    exp_t e;
    e.idx = idx; e.tag = tag;
    e.val = (idx < NEV) ? mcnt[idx] : 0;
    e.ovf = (idx < NEV) ? movf[idx] : 1'b0;
    sb_q.push_back(e);
    rd_idx  = 5'(idx);
    rd_pend = 1'b1;
    cyc(1'b0, 1'b1, 2'b00, '0, 0, 1'b0, 1'b0);
    rd_pend = 1'b0;
  endtask

  always @(posedge clk) rd_pend_q <= rd_pend;

  // monitor: compare registered read results against queued expectations
  always @(negedge clk) begin
    if (rd_pend_q && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if (rd_data != CW'(e.val) || rd_ovf != e.ovf) begin
        n_fail++;
        $display("FAIL %s idx %0d: got %0d/ovf %0d, expected %0d/ovf %0d",
                 e.tag, e.idx, rd_data, rd_ovf, e.val, e.ovf);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NEV; i++) begin mcnt[i] = 0; movf[i] = 0; end
    own = 0; own_vld = 0; rd_pend = 0; rd_pend_q = 0;
    rst_n = 1'b0; hwrite = 0; hready = 1; htrans = 0; hgrant = '0;
    hmaster = 0; cnt_en = 1; cnt_clr = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: arming edge carries activity that must not be counted
    skip = 1'b1;
    cyc(1'b1, 1'b1, 2'b10, 4'b0001, 0, 1'b1, 1'b0);
    for (int i = 0; i < NEV; i++) rd(i, "R10");

    // data, overhead and idle mix
    cyc(1'b1, 1'b1, 2'b10, 4'b0010, 1, 1'b1, 1'b0);  // R1 write NONSEQ, owner->1
    cyc(1'b1, 1'b1, 2'b11, 4'b0010, 1, 1'b1, 1'b0);  // R6 credited to master 1
    cyc(1'b1, 1'b0, 2'b11, 4'b0010, 1, 1'b1, 1'b0);  // R3 wait state, not idle
    cyc(1'b1, 1'b1, 2'b01, 4'b0010, 1, 1'b1, 1'b0);  // BUSY: no data
    cyc(1'b0, 1'b1, 2'b10, 4'b0100, 2, 1'b1, 1'b0);  // R2 read
    cyc(1'b0, 1'b0, 2'b11, 4'b0100, 2, 1'b1, 1'b0);  // R5 owner held
    cyc(1'b0, 1'b1, 2'b11, 4'b0100, 2, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 2'b00, 4'b1001, 3, 1'b1, 1'b0);  // R4 two grants
    cyc(1'b0, 1'b1, 2'b00, 4'b0000, 0, 1'b1, 1'b0);  // R3 idle
    cyc(1'b1, 1'b1, 2'b10, 4'b0000, 0, 1'b1, 1'b0);  // R3 idle with data
    rd(0, "R1"); rd(1, "R2"); rd(2, "R3");
    for (int m = 0; m < NM; m++) begin
      rd(3 + 4*m, "R4"); rd(4 + 4*m, "R5");
      rd(5 + 4*m, "R6"); rd(6 + 4*m, "R6");
    end

    // R7: disabled activity ignored, owner still tracked
    cyc(1'b1, 1'b1, 2'b10, 4'b1000, 3, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 2'b11, 4'b1000, 3, 1'b0, 1'b0);
    rd(0, "R7"); rd(1, "R7"); rd(2, "R7"); rd(15, "R7");
    cyc(1'b1, 1'b1, 2'b10, 4'b1000, 3, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 2'b11, 4'b0000, 3, 1'b1, 1'b0);
    rd(16, "R7"); rd(2, "R7");

    // R11: repeated read has no side effect
    rd(0, "R11"); rd(0, "R11");
    rd(25, "R11"); rd(31, "R11"); rd(19, "R11");

    // R9: idle overflow
    for (int k = 0; k < 70; k++) cyc(1'b0, 1'b1, 2'b00, '0, 1, 1'b1, 1'b0);
    rd(2, "R9"); rd(8, "R9"); rd(0, "R9"); rd(3, "R9");

    // R8: clear wins over simultaneous events
    cyc(1'b1, 1'b1, 2'b10, 4'b0000, 1, 1'b1, 1'b1);
    rd(2, "R8"); rd(8, "R8"); rd(0, "R8"); rd(1, "R8");
    cyc(1'b0, 1'b1, 2'b11, 4'b0010, 1, 1'b1, 1'b0);
    rd(1, "R8"); rd(10, "R8"); rd(7, "R8");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule